// File: doc/BRIEF.md
# Game of Life Generation Engine with Repeat-Triggered Reseeding

This block runs Conway's Game of Life on an 8x8 board intended to drive a 64-LED matrix. Each pulse on the step input advances the displayed board by one generation. Cells just outside the board are not dead and do not wrap around. They come from a fixed checkerboard ring, so edge and corner cells keep getting live neighbours and can sustain activity.

A second copy of the board advances two generations for every step. When that fast copy catches up with the displayed copy, the run has entered a loop. An all-dead board also ends a run. In either case the block draws a fresh board from a 23-bit maximal-length LFSR, raises a one-cycle flag, and starts the run again. The surrounding display logic only needs to issue step strobes and show the board output.

Top module: `lifeEngine`

## Requirements
- R1: During reset the board output is all zero and the reseed flag is low. The LFSR state resets to 23'h000001. Because the board is dead, the flag rises in the first cycle after reset is released.
- R2: A reseed clocks the LFSR 64 times. Each clock forms fb = s[22] ^ s[17] (polynomial x^23 + x^18 + 1) and updates s to {s[21:0], fb}. The k-th fb value (k = 0..63) becomes board bit k, which is row k/8, column k%8.
- R3: A step applies the usual rules. A live cell with 2 or 3 live neighbours stays live. A dead cell with exactly 3 live neighbours becomes live. Every other cell is dead in the next generation.
- R4: A neighbour outside the board at row r, column c (each ranging from -1 to 8) counts as live exactly when r+c is even. This ring never changes.
- R5: A step strobe sampled high at a clock edge updates the board output after that edge. When no strobe is sampled and no reseed is loading, the board output holds its value.
- R6: A slow copy advances one generation per step and a fast copy advances two. When the two copies are equal after at least one step since the last reseed, a reseed begins.
- R7: An all-dead displayed board starts a reseed.
- R8: The reseed flag is high for exactly one cycle per reseed. The new board appears on the output in the cycle after the flag, and both copies restart from it.
- R9: A step strobe sampled while a reseed is pending or while the flag is high has no effect. The board loaded afterwards is the unmodified new seed.
- R10: The LFSR state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| stepStrobe | input | 1 | Advance one generation when sampled high |
| board | output | 64 | Displayed board, bit k is row k/8, column k%8, 1 = live |
| reseedPulse | output | 1 | One-cycle flag marking a reseed |

## Verification
The bench drives the step strobe with varied run lengths and idle gaps. Long stepping runs carry many seeds through their transients into still lifes and oscillators. This separates the neighbour-count rules and the border parity, which decide every step's expected board, from the repeat detector, which decides when the run ends. Idle gaps show that the board holds between strobes. Strobes held high through each pending reseed show that the seed loads untouched. The expected seeds come from an independent LFSR model, so a wrong tap, shift direction or bit order shows up at the first seed.

// File: rtl/lifePkg.sv
package lifePkg;
  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int CELLS = ROWS * COLS;

  typedef logic [CELLS-1:0] board_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // take a new seed into both copies
    logic advance;  // step slow copy once, fast copy twice
  } ctlStrobes_t;

  // cell value, with the fixed checkerboard ring outside the board
  function automatic logic cellAt(board_t b, int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS)
      return ((r + c) & 1) == 0;
    return b[r * COLS + c];
  endfunction

  function automatic board_t nextGen(board_t b);
    board_t n;
    int cnt;
    n = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        cnt = 0;
        for (int dr = -1; dr <= 1; dr++) begin
          for (int dc = -1; dc <= 1; dc++) begin
            if ((dr != 0 || dc != 0) && cellAt(b, r + dr, c + dc))
              cnt++;
          end
        end
        n[r * COLS + c] = (cnt == 3) || (cnt == 2 && b[r * COLS + c]);
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/lifeDatapath.sv
module lifeDatapath
  import lifePkg::*;
#(
  parameter int              LFSR_W = 23,
  parameter int              TAP_LO = 18,
  parameter logic [LFSR_W-1:0] SEED = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  output board_t      board,
  output logic        repeatHit,
  output logic        deadHit
);
  logic [LFSR_W-1:0] lfsrQ, lfsrNext;
  board_t tortQ, hareQ, seedBits;
  board_t tortNext, hareMid, hareNext;
  logic   steppedQ;

  // all 64 LFSR clocks of one reseed, unrolled into one cycle
  always_comb begin : seedGen
    logic [LFSR_W-1:0] s;
    logic fb;
    s        = lfsrQ;
    seedBits = '0;
    for (int k = 0; k < CELLS; k++) begin
      fb          = s[LFSR_W-1] ^ s[TAP_LO-1];
      seedBits[k] = fb;
      s           = {s[LFSR_W-2:0], fb};
    end
    lfsrNext = s;
  end

  always_comb begin
    tortNext = nextGen(tortQ);
    hareMid  = nextGen(hareQ);
    hareNext = nextGen(hareMid);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ    <= SEED;
      tortQ    <= '0;
      hareQ    <= '0;
      steppedQ <= 1'b0;
    end else if (ctl.load) begin
      lfsrQ    <= lfsrNext;
      tortQ    <= seedBits;
      hareQ    <= seedBits;
      steppedQ <= 1'b0;
    end else if (ctl.advance) begin
      tortQ    <= tortNext;
      hareQ    <= hareNext;
      steppedQ <= 1'b1;
    end
  end

  assign board     = tortQ;
  assign repeatHit = steppedQ && (tortQ == hareQ);
  assign deadHit   = (tortQ == '0);

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);  // R10
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.advance) |=> ($stable(tortQ) && $stable(hareQ)));  // R5
  AST_COPIES_MATCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (tortQ == hareQ));  // R8
  AST_SEED_ALIVE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (tortQ != '0));  // R2
  AST_REPEAT_RESEEDS: assert property (@(posedge clk) disable iff (!rstN)
    (repeatHit && !ctl.load) |=> ctl.load);  // R6
  AST_DEAD_RESEEDS: assert property (@(posedge clk) disable iff (!rstN)
    (deadHit && !ctl.load) |=> ctl.load);  // R7
endmodule

// File: rtl/lifeControl.sv
module lifeControl
  import lifePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepStrobe,
  input  logic        repeatHit,
  input  logic        deadHit,
  output ctlStrobes_t ctl,
  output logic        reseedPulse
);
  logic pulseQ;
  logic pending;

  assign pending = repeatHit || deadHit;

  always_ff @(posedge clk) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= !pulseQ && pending;
  end

  always_comb begin
    ctl.load    = pulseQ;
    ctl.advance = stepStrobe && !pulseQ && !pending;  // R9 gating
  end

  assign reseedPulse = pulseQ;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);  // R8
  AST_NO_STEP_WHILE_RESEED: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ || pending) |-> !ctl.advance);  // R9
endmodule

// File: rtl/lifeEngine.sv
module lifeEngine #(
  parameter int                LFSR_W = 23,
  parameter int                TAP_LO = 18,
  parameter logic [LFSR_W-1:0] SEED   = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      stepStrobe,
  output logic [lifePkg::CELLS-1:0] board,
  output logic                      reseedPulse
);
  lifePkg::ctlStrobes_t ctl;
  logic repeatHit, deadHit;

  lifeControl ctrl_i (
    .clk(clk), .rstN(rstN), .stepStrobe(stepStrobe),
    .repeatHit(repeatHit), .deadHit(deadHit),
    .ctl(ctl), .reseedPulse(reseedPulse)
  );

  lifeDatapath #(.LFSR_W(LFSR_W), .TAP_LO(TAP_LO), .SEED(SEED)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .board(board), .repeatHit(repeatHit), .deadHit(deadHit)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (board == '0 && !reseedPulse));  // R1
endmodule

// File: tb/lifeEngine_tb.sv
module lifeEngine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_PLAN     = 8;
  localparam int PLAN_STEPS [N_PLAN] = '{5, 40, 200, 400, 600, 400, 300, 100};
  localparam int PLAN_GAP   [N_PLAN] = '{3, 0, 1, 0, 2, 0, 1, 4};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepStrobe = 1'b0;
  logic [63:0] board;
  logic        reseedPulse;

  int checks = 0;
  int fails = 0;
  int reseeds = 0;
  bit done = 1'b0;

  logic [22:0] mLfsr;
  logic [63:0] mSlow, mFast;
  bit          mStepped;

  always #(CLK_PERIOD/2) clk = ~clk;

  lifeEngine dut_i (
    .clk(clk), .rstN(rstN), .stepStrobe(stepStrobe),
    .board(board), .reseedPulse(reseedPulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // independent reference: padded 10x10 grid, ring live where row+col even
  function automatic logic [63:0] refStep(input logic [63:0] b);
    logic g [10][10];
    logic [63:0] n;
    int sum;
    for (int gr = 0; gr < 10; gr++)
      for (int gc = 0; gc < 10; gc++)
        if (gr >= 1 && gr <= 8 && gc >= 1 && gc <= 8) g[gr][gc] = b[(gr-1)*8 + (gc-1)];
        else g[gr][gc] = ((gr + gc) % 2) == 0;
    for (int k = 0; k < 64; k++) begin
      sum = 0;
      for (int gr = k/8; gr <= k/8 + 2; gr++)
        for (int gc = k%8; gc <= k%8 + 2; gc++)
          if (g[gr][gc]) sum++;
      if (b[k]) sum--;
      n[k] = (sum == 3) || (sum == 2 && b[k]);
    end
    return n;
  endfunction

  function automatic logic [63:0] refSeed(inout logic [22:0] s);
    logic [63:0] bits;
    logic f;
    for (int k = 0; k < 64; k++) begin
      f = s[22] ^ s[17];
      bits[k] = f;
      s = {s[21:0], f};
    end
    return bits;
  endfunction

  task automatic resetAndSeed();
    logic [63:0] exp;
    rstN = 1'b0;
    stepStrobe = 1'b0;
    repeat (3) @(negedge clk);
    chk(board == 64'd0, "R1 board clear in reset", board, 64'd0);
    chk(reseedPulse == 1'b0, "R1 flag low in reset", {63'd0, reseedPulse}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reseedPulse == 1'b1, "R1 R7 dead board flags reseed", {63'd0, reseedPulse}, 64'd1);
    stepStrobe = 1'b1;  // sampled while flag is high: must be ignored
    @(negedge clk);
    stepStrobe = 1'b0;
    mLfsr = 23'h000001;
    exp = refSeed(mLfsr);
    chk(board == exp, "R2 R8 R9 first seed", board, exp);
    chk(reseedPulse == 1'b0, "R8 flag single cycle", {63'd0, reseedPulse}, 64'd0);
    mSlow = exp; mFast = exp; mStepped = 1'b0;
    reseeds++;
  endtask

  task automatic doStep();
    logic [63:0] exp;
    stepStrobe = 1'b1;
    @(negedge clk);
    mSlow = refStep(mSlow);
    mFast = refStep(refStep(mFast));
    mStepped = 1'b1;
    chk(board == mSlow, "R3 R4 R5 generation", board, mSlow);
    chk(reseedPulse == 1'b0, "R5 no flag on step", {63'd0, reseedPulse}, 64'd0);
    if (mSlow == 64'd0 || mSlow == mFast) begin
      // keep the strobe high through the pending and flag cycles (R9)
      @(negedge clk);
      chk(reseedPulse == 1'b1, "R6 R7 reseed flag", {63'd0, reseedPulse}, 64'd1);
      chk(board == mSlow, "R9 board held while pending", board, mSlow);
      @(negedge clk);
      stepStrobe = 1'b0;
      exp = refSeed(mLfsr);
      chk(board == exp, "R2 R8 R9 new seed after flag", board, exp);
      chk(reseedPulse == 1'b0, "R8 flag single cycle", {63'd0, reseedPulse}, 64'd0);
      mSlow = exp; mFast = exp; mStepped = 1'b0;
      reseeds++;
    end else begin
      stepStrobe = 1'b0;
    end
  endtask

  initial begin
    logic [63:0] held;
    resetAndSeed();
    for (int p = 0; p < N_PLAN; p++) begin
      for (int s = 0; s < PLAN_STEPS[p]; s++) begin
        doStep();
        held = board;
        for (int g = 0; g < PLAN_GAP[p]; g++) begin
          @(negedge clk);
          chk(board == held, "R5 hold without strobe", board, held);
        end
      end
    end
    chk(reseeds >= 3, "R6 R7 runs ended and reseeded", 64'(reseeds), 64'd3);
    // a second reset must restart the same seed sequence
    resetAndSeed();
    doStep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule